// File: doc/BRIEF.md
# Masked Status Interrupt Collector

This block collects six event sources into one status byte and raises a single level interrupt when any source is both present and enabled. Four general-purpose input pins are synchronized and watched for any change of level; each change latches a sticky flag that a host clears by reading the status byte. Two further flags, a sleep indication and a clock-ready indication, are not sticky. Each one mirrors its external source, gated by the clock-enable state, so a read leaves it unchanged.

A host reaches two byte-wide registers through a plain strobe-based register port. The enable register at address 0x07 can be read and written. The status register at address 0x08 is read-only, and reading it clears its sticky flags. Read data appears one cycle after the read strobe and shows the contents from before the clear. The interrupt output is the OR of all status bits whose enable bit is set.

Top module: `stat_irq_unit`

## Requirements
- R1: After reset, the enable and status registers both read 0x00 and `irq_out` is low.
- R2: A write strobe at address 0x07 stores the write data into the enable register. Bit 6 enables the sleep flag, bit 5 enables the clock-ready flag and bits 3..0 enable the four pin flags. Bits 7 and 4 of every read value are always zero.
- R3: A change of level on `gpi_in[i]`, rising or falling, sets status bit i (i = 0..3) three clock edges after the pin changes, counted across a two-flop synchronizer and a previous-sample register.
- R4: A read strobe at address 0x08 returns the status byte as it stood before the read on `reg_rdata` during the following cycle. In that same following cycle, status bits 3..0 read back as zero.
- R5: If a pin change is detected in the cycle of a status read, its flag stays set after the read.
- R6: Status bit 6 equals `sleep_active AND clk_enabled`, delayed by one clock. A read does not clear it.
- R7: Status bit 5 equals `clk_settled AND clk_enabled AND NOT ext_clk_sel`, delayed by one clock. A read does not clear it.
- R8: `irq_out` is high exactly when some status bit and the enable bit at the same position are both high. Status bits whose enable bit is low have no effect on it.
- R9: Writes to 0x08 change nothing. Reads of any address other than 0x07 and 0x08 return 0x00 and clear no flag. When no read strobe is present, `reg_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpi_in | input | 4 | Asynchronous general-purpose input pins |
| sleep_active | input | 1 | High while the device is in sleep mode |
| clk_enabled | input | 1 | High while the core clock is enabled |
| clk_settled | input | 1 | High once the oscillator, divider and PLL have settled |
| ext_clk_sel | input | 1 | High when external clocking is selected |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| irq_out | output | 1 | Summary interrupt level |

## Verification
A pin flag that is stuck, or that is cleared at the wrong moment, shows up in the next status read, which comes two cycles after the read strobe is presented. It also shows up at once on `irq_out` whenever that bit is enabled. A faulty enable bit changes `irq_out` in the cycle after the write, and the following read of address 0x07 exposes it. A level flag that a read wrongly clears, or that ignores its gating inputs, differs from its source on the second consecutive status read. A lost event when a pin change and a read coincide shows as a missing flag on the read that follows.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int NUM_GPI    = 4;
  localparam int SYNC_DEPTH = 2;
  localparam int BIT_SLEEP  = 6;
  localparam int BIT_CLKRDY = 5;

  localparam logic [ADDR_W-1:0] EN_ADDR = 8'h07;
  localparam logic [ADDR_W-1:0] ST_ADDR = 8'h08;

  // bits that carry a function in both registers
  function automatic logic [DATA_W-1:0] live_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[NUM_GPI-1:0] = '1;
    m[BIT_SLEEP]   = 1'b1;
    m[BIT_CLKRDY]  = 1'b1;
    return m;
  endfunction

  // summary interrupt: any source both pending and enabled
  function automatic logic irq_any(input logic [DATA_W-1:0] st,
                                   input logic [DATA_W-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/gpi_change_det.sv
module gpi_change_det #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] chg
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], pin[g]};
        prev <= sh[STAGES-1];
      end
    end
    assign chg[g] = sh[STAGES-1] ^ prev;
  end
endmodule

// File: rtl/stat_flags.sv
module stat_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] chg,
  input  logic         rd_clr,
  input  logic         sleep_lvl,
  input  logic         rdy_lvl,
  output logic [N-1:0] gpi_st,
  output logic         sleep_st,
  output logic         rdy_st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpi_st   <= '0;
      sleep_st <= 1'b0;
      rdy_st   <= 1'b0;
    end else begin
      // a fresh event wins over the clear so nothing is lost
      gpi_st   <= (gpi_st & ~{N{rd_clr}}) | chg;
      sleep_st <= sleep_lvl;
      rdy_st   <= rdy_lvl;
    end
  end
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
  import stat_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_GPI-1:0] gpi_in,
  input  logic              sleep_active,
  input  logic              clk_enabled,
  input  logic              clk_settled,
  input  logic              ext_clk_sel,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam logic [DATA_W-1:0] LIVE = live_mask();

  logic [NUM_GPI-1:0] gpi_chg;
  logic [NUM_GPI-1:0] gpi_st;
  logic               sleep_st, rdy_st;
  logic [DATA_W-1:0]  stat_byte;
  logic [DATA_W-1:0]  en_q;
  logic [DATA_W-1:0]  rd_mux;
  logic               en_wr_hit, st_rd_hit;
  logic               sleep_lvl, rdy_lvl;

  assign en_wr_hit = reg_wr && (reg_addr == EN_ADDR);
  assign st_rd_hit = reg_rd && (reg_addr == ST_ADDR);
  assign sleep_lvl = sleep_active && clk_enabled;
  assign rdy_lvl   = clk_settled && clk_enabled && !ext_clk_sel;

  gpi_change_det #(.N(NUM_GPI), .STAGES(SYNC_DEPTH)) u_det (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (gpi_in),
    .chg  (gpi_chg)
  );

  stat_flags #(.N(NUM_GPI)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .chg      (gpi_chg),
    .rd_clr   (st_rd_hit),
    .sleep_lvl(sleep_lvl),
    .rdy_lvl  (rdy_lvl),
    .gpi_st   (gpi_st),
    .sleep_st (sleep_st),
    .rdy_st   (rdy_st)
  );

  always_comb begin
    stat_byte              = '0;
    stat_byte[NUM_GPI-1:0] = gpi_st;
    stat_byte[BIT_SLEEP]   = sleep_st;
    stat_byte[BIT_CLKRDY]  = rdy_st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (en_wr_hit) en_q <= reg_wdata & LIVE;
  end

  always_comb begin
    unique case (reg_addr)
      EN_ADDR: rd_mux = en_q;
      ST_ADDR: rd_mux = stat_byte;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= reg_rd ? rd_mux : '0;
  end

  assign irq_out = irq_any(stat_byte, en_q);
endmodule

// File: rtl/stat_irq_chk.sv
module stat_irq_chk
  import stat_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq_out,
  input logic [NUM_GPI-1:0] gpi_chg,
  input logic [DATA_W-1:0]  stat_byte,
  input logic [DATA_W-1:0]  en_q,
  input logic               sleep_active,
  input logic               clk_enabled,
  input logic               clk_settled,
  input logic               ext_clk_sel
);
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] == 1'b0) && (reg_rdata[4] == 1'b0));

  a_r3_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|gpi_chg) |=> ((stat_byte[NUM_GPI-1:0] & $past(gpi_chg)) == $past(gpi_chg)));

  a_r4_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ST_ADDR) |=> (reg_rdata == $past(stat_byte)));

  a_r4_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ST_ADDR && gpi_chg == '0) |=> (stat_byte[NUM_GPI-1:0] == '0));

  a_r6_sleep_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_byte[BIT_SLEEP] == $past(sleep_active && clk_enabled)));

  a_r7_ready_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_byte[BIT_CLKRDY] == $past(clk_settled && clk_enabled && !ext_clk_sel)));

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_byte & en_q) == '0) |-> !irq_out);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != EN_ADDR && reg_addr != ST_ADDR) |=> (reg_rdata == '0));
endmodule

bind stat_irq_unit stat_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .irq_out     (irq_out),
  .gpi_chg     (gpi_chg),
  .stat_byte   (stat_byte),
  .en_q        (en_q),
  .sleep_active(sleep_active),
  .clk_enabled (clk_enabled),
  .clk_settled (clk_settled),
  .ext_clk_sel (ext_clk_sel)
);

// File: tb/stat_irq_unit_tb.sv
`timescale 1ns/1ps
module stat_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] gpi_in = 4'h0;
  logic       sleep_active = 1'b0, clk_enabled = 1'b0;
  logic       clk_settled = 1'b0, ext_clk_sel = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stat_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .gpi_in(gpi_in),
    .sleep_active(sleep_active), .clk_enabled(clk_enabled),
    .clk_settled(clk_settled), .ext_clk_sel(ext_clk_sel),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // flip the pins in m and wait until the flags are latched (3 edges)
  task automatic flip(input logic [3:0] m);
    @(negedge clk); gpi_in = gpi_in ^ m;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic levels(input logic s, input logic e, input logic r, input logic x);
    @(negedge clk);
    sleep_active = s; clk_enabled = e; clk_settled = r; ext_clk_sel = x;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {7'd0, irq_out}, 8'h00);
    rd(8'h07, d); chk("R1 enable", d, 8'h00);
    rd(8'h08, d); chk("R1 status", d, 8'h00);
    chk("R9 idle rdata", reg_rdata, 8'h00);

    // R3/R4/R8: each pin, both directions, enabled
    wr(8'h07, 8'h0F);
    for (int i = 0; i < 4; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        flip(4'(1 << i));
        chk("R8 irq on", {7'd0, irq_out}, 8'h01);
        rd(8'h08, d); chk("R3 flag", d, 8'(1 << i));
        rd(8'h08, d); chk("R4 cleared", d, 8'h00);
        chk("R8 irq off", {7'd0, irq_out}, 8'h00);
      end
    end

    // R8: each pin masked alone
    for (int i = 0; i < 4; i++) begin
      wr(8'h07, 8'h0F & ~8'(1 << i));
      flip(4'(1 << i));
      chk("R8 masked", {7'd0, irq_out}, 8'h00);
      rd(8'h08, d); chk("R3 masked flag", d, 8'(1 << i));
    end

    // R5: change detected in the read cycle survives
    wr(8'h07, 8'h0F);
    @(negedge clk); gpi_in[0] = ~gpi_in[0];
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h08;
    @(negedge clk); reg_rd = 1'b0;
    chk("R5 pre-read", reg_rdata, 8'h00);
    rd(8'h08, d); chk("R5 kept", d, 8'h01);

    // R9: status write ignored, unmapped reads zero and non-clearing
    flip(4'h4);
    wr(8'h08, 8'h00);
    wr(8'h08, 8'hFF);
    for (int a = 0; a < 256; a++) begin
      if (a != 7 && a != 8) begin
        rd(8'(a), d); chk("R9 unmapped", d, 8'h00);
      end
    end
    rd(8'h07, d); chk("R2 readback", d, 8'h0F);
    rd(8'h08, d); chk("R9 status intact", d, 8'h04);
    rd(8'h08, d); chk("R4 cleared", d, 8'h00);

    // R6/R7: level flags
    levels(1, 1, 1, 0);
    rd(8'h08, d); chk("R6 R7 set", d, 8'h60);
    rd(8'h08, d); chk("R6 R7 not cleared", d, 8'h60);
    levels(1, 1, 1, 1);
    rd(8'h08, d); chk("R7 ext clock", d, 8'h40);
    levels(1, 0, 1, 0);
    rd(8'h08, d); chk("R6 R7 clock off", d, 8'h00);
    levels(0, 1, 1, 0);
    rd(8'h08, d); chk("R6 awake", d, 8'h20);
    levels(1, 1, 0, 0);
    rd(8'h08, d); chk("R7 unsettled", d, 8'h40);
    levels(1, 1, 1, 0);

    // R2/R8: enable sweep with every source pending
    flip(4'hF);
    for (int e = 0; e < 256; e++) begin
      wr(8'h07, 8'(e));
      chk("R8 sweep all", {7'd0, irq_out}, {7'd0, ((e & 8'h6F) != 0)});
      rd(8'h07, d); chk("R2 sweep", d, 8'(e) & 8'h6F);
    end
    rd(8'h08, d); chk("R4 R6 R7 full", d, 8'h6F);
    for (int e = 0; e < 256; e++) begin
      wr(8'h07, 8'(e));
      chk("R8 sweep levels", {7'd0, irq_out}, {7'd0, ((e & 8'h60) != 0)});
    end
    rd(8'h08, d); chk("R4 R6 R7 after", d, 8'h60);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule